// File: doc/BRIEF.md
# Smart Panel Command/Data Serial Transmitter

This block sends single bytes to a display module that keeps its own frame store. A byte arrives with a flag that marks it as a command or as display data, through a valid/ready handshake. The block then runs one bus transfer and holds `busy` high until that transfer ends.

In serial mode the byte goes out on a select, clock and data line, most significant bit first. A register-select line tells the panel whether the byte is a command or pixel data. In parallel mode the whole byte appears on an 8-bit bus and a single write strobe marks it. Two settings choose the resting level of the serial clock and the active level of chip select. The block samples the mode and both polarity settings when it accepts a byte.

Timing is counted in phases of `DIV_HALF` system cycles, and one bus clock is two phases. A serial transfer is one bus clock of select setup, eight bit slots of one bus clock each, and one bus clock of hold. That is 20·`DIV_HALF` cycles of `busy`. A parallel transfer is setup, one strobe slot and hold, which is 6·`DIV_HALF` cycles.

Top module: `slcd_tx`

## Requirements
- R1: `in_ready` is high exactly when `busy` is low. A byte is taken on a rising clock edge with `in_valid` and `in_ready` both high, and `busy` is high in the cycle after that edge. `in_valid` pulses while `busy` is high are ignored: they alter neither the byte sent nor the length of the transfer, and they start no new transfer.
- R2: `lcd_rs` is 0 for a command byte (`in_is_data`=0) and 1 for a display byte (`in_is_data`=1). It holds that value for the whole time chip select is active.
- R3: In serial mode (`cfg_par`=0), the eight leading clock edges each carry one bit on `lcd_sdo`, bit 7 first and bit 0 last.
- R4: The serial clock rests at the level of `cfg_sclk_idle_hi` (0 = low, 1 = high), and the leading edge moves it away from that level. The first leading edge comes 3·`DIV_HALF` cycles after acceptance.
- R5: Chip select is active at level `cfg_cs_act_hi` (1 = active high, 0 = active low) for the whole transfer and inactive otherwise.
- R6: Chip select is active at least one bus clock (2·`DIV_HALF` cycles) before the first leading edge. It stays active for exactly one bus clock after the last trailing edge.
- R7: In parallel mode (`cfg_par`=1), exactly one `lcd_wr` pulse occurs, `DIV_HALF` cycles wide, with the byte on `lcd_pdata`. The serial clock does not toggle.
- R8: `busy` stays high for 20·`DIV_HALF` cycles for a serial transfer and 6·`DIV_HALF` cycles for a parallel one.
- R9: The mode and polarities are taken when a byte is accepted. Changing them mid-transfer does not affect that transfer. While idle, the clock and select lines follow the current settings.
- R10: After reset, `busy` is low, `in_ready` is high, chip select is inactive and the clock rests at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| cfg_par | input | 1 | 1 = parallel bus, 0 = serial |
| cfg_sclk_idle_hi | input | 1 | Resting level of serial clock |
| cfg_cs_act_hi | input | 1 | Active level of chip select |
| busy | output | 1 | Transfer in progress |
| lcd_cs | output | 1 | Chip select |
| lcd_sclk | output | 1 | Serial clock |
| lcd_sdo | output | 1 | Serial data |
| lcd_rs | output | 1 | Register select (command/data) |
| lcd_wr | output | 1 | Parallel write strobe, active high |
| lcd_pdata | output | 8 | Parallel data bus |

## Verification
Every output is decoded from registers, so each result is due at a fixed offset from the accepting edge. `busy` is due one cycle later. The first serial leading edge comes at cycle 3·`DIV_HALF`+1, the last trailing edge at 18·`DIV_HALF`+1, and the select release at 20·`DIV_HALF`+1. In parallel mode the strobe rises at 3·`DIV_HALF`+1 and the select releases at 6·`DIV_HALF`+1. The bench counts cycles from the accepting edge and samples just after each falling edge. It compares every line against these computed offsets over all mode, polarity and command/data combinations with several byte patterns.

// File: rtl/slcd_tx.sv
module slcd_tx #(
  parameter int DIV_HALF = 2,
  parameter int W        = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_is_data,
  input  logic         cfg_par,
  input  logic         cfg_sclk_idle_hi,
  input  logic         cfg_cs_act_hi,
  output logic         busy,
  output logic         lcd_cs,
  output logic         lcd_sclk,
  output logic         lcd_sdo,
  output logic         lcd_rs,
  output logic         lcd_wr,
  output logic [W-1:0] lcd_pdata
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int PW = $clog2(2*W);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_BITS, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] div;
  logic [PW-1:0] ph;
  logic [W-1:0]  sh;
  logic          rs_q, par_q, ckh_q, csh_q;

  wire tick    = (div == '0);
  wire last_ph = (st == S_BITS) ? (ph == (par_q ? PW'(1) : PW'(2*W-1))) : (ph == PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      div   <= '0;
      ph    <= '0;
      sh    <= '0;
      rs_q  <= 1'b0;
      par_q <= 1'b0;
      ckh_q <= 1'b0;
      csh_q <= 1'b0;
    end else if (st == S_IDLE) begin
      if (in_valid) begin
        st    <= S_SETUP;
        div   <= CW'(DIV_HALF-1);
        ph    <= '0;
        sh    <= in_data;
        rs_q  <= in_is_data;
        par_q <= cfg_par;
        ckh_q <= cfg_sclk_idle_hi;
        csh_q <= cfg_cs_act_hi;
      end
    end else if (!tick) begin
      div <= div - 1'b1;
    end else begin
      div <= CW'(DIV_HALF-1);
      if (last_ph) begin
        ph <= '0;
        case (st)
          S_SETUP: st <= S_BITS;
          S_BITS:  st <= S_HOLD;
          default: st <= S_IDLE;
        endcase
      end else begin
        ph <= ph + 1'b1;
        if (st == S_BITS && !par_q && ph[0])
          sh <= sh << 1;
      end
    end
  end

  wire sclk_act = (st == S_BITS) && !par_q && ph[0];

  assign busy      = (st != S_IDLE);
  assign in_ready  = !busy;
  assign lcd_cs    = busy ? csh_q : !cfg_cs_act_hi;
  assign lcd_sclk  = busy ? (sclk_act ^ ckh_q) : cfg_sclk_idle_hi;
  assign lcd_sdo   = busy && !par_q && sh[W-1];
  assign lcd_rs    = busy && rs_q;
  assign lcd_wr    = (st == S_BITS) && par_q && ph[0];
  assign lcd_pdata = (busy && par_q) ? sh : '0;

endmodule

// File: rtl/slcd_tx_chk.sv
module slcd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic busy,
  input logic cfg_sclk_idle_hi,
  input logic cfg_cs_act_hi,
  input logic lcd_cs,
  input logic lcd_sclk,
  input logic lcd_rs,
  input logic lcd_wr
);

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  p_busy_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid));

  p_rs_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lcd_rs));

  p_sclk_rest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_sclk == cfg_sclk_idle_hi));

  p_cs_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lcd_cs == !cfg_cs_act_hi));

  p_strobe_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_wr |-> (busy && $stable(lcd_sclk) && $stable(lcd_cs)));

endmodule

bind slcd_tx slcd_tx_chk u_chk (.*);

// File: tb/slcd_tx_tb.sv
module slcd_tx_tb;

  localparam int H = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_is_data = 1'b0;
  logic       cfg_par = 1'b0;
  logic       cfg_sclk_idle_hi = 1'b0;
  logic       cfg_cs_act_hi = 1'b0;
  logic       busy, lcd_cs, lcd_sclk, lcd_sdo, lcd_rs, lcd_wr;
  logic [7:0] lcd_pdata;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  slcd_tx #(.DIV_HALF(H), .W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_is_data(in_is_data), .cfg_par(cfg_par),
    .cfg_sclk_idle_hi(cfg_sclk_idle_hi), .cfg_cs_act_hi(cfg_cs_act_hi),
    .busy(busy), .lcd_cs(lcd_cs), .lcd_sclk(lcd_sclk), .lcd_sdo(lcd_sdo),
    .lcd_rs(lcd_rs), .lcd_wr(lcd_wr), .lcd_pdata(lcd_pdata)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input logic isd, input logic par,
                      input logic ckh, input logic csh);
    int T = par ? 6*H : 20*H;
    int end_k = 0, cs_err = 0, rs_err = 0, nlead = 0, first_lead = 0;
    int last_trail = 0, nwr = 0, wr_hi = 0;
    logic [7:0] cap = '0, pcap = '0;
    logic prev_sclk, prev_wr;
    @(negedge clk);
    cfg_par = par; cfg_sclk_idle_hi = ckh; cfg_cs_act_hi = csh;
    in_data = b; in_is_data = isd; in_valid = 1'b1;
    #1;
    chk(lcd_sclk == ckh, "R4 idle clock", lcd_sclk, ckh);
    chk(lcd_cs == !csh, "R5 idle select", lcd_cs, !csh);
    chk(in_ready == 1'b1, "R1 ready when idle", in_ready, 1);
    prev_sclk = lcd_sclk;
    prev_wr = lcd_wr;
    for (int k = 1; k <= T + 2; k++) begin
      @(negedge clk);
      if (k == 1) in_valid = 1'b0;
      if (k == 3) begin in_valid = 1'b1; in_data = ~b; in_is_data = !isd; end
      if (k == 4) in_valid = 1'b0;
      if (k == 5) begin cfg_par = !par; cfg_sclk_idle_hi = !ckh; cfg_cs_act_hi = !csh; end
      #1;
      if (k == 1) chk(busy && !in_ready, "R1 busy after accept", busy, 1);
      if (!busy && end_k == 0) end_k = k;
      if (k <= T) begin
        if (lcd_cs != csh) cs_err++;
        if (lcd_rs != isd) rs_err++;
        if (prev_sclk == ckh && lcd_sclk != ckh) begin
          nlead++;
          cap = {cap[6:0], lcd_sdo};
          if (first_lead == 0) first_lead = k;
        end
        if (prev_sclk != ckh && lcd_sclk == ckh) last_trail = k;
        if (lcd_wr) wr_hi++;
        if (lcd_wr && !prev_wr) begin nwr++; pcap = lcd_pdata; end
      end else if (lcd_cs != !cfg_cs_act_hi) cs_err++;
      if (k == T + 1) begin
        chk(lcd_sclk == cfg_sclk_idle_hi, "R9 idle clock follows setting", lcd_sclk, cfg_sclk_idle_hi);
        chk(lcd_cs == !cfg_cs_act_hi, "R9 idle select follows setting", lcd_cs, !cfg_cs_act_hi);
      end
      if (k == T + 2) chk(!busy, "R1 ignored valid caused no restart", busy, 0);
      prev_sclk = lcd_sclk;
      prev_wr = lcd_wr;
    end
    chk(end_k == T + 1, "R8 busy length", end_k - 1, T);
    chk(cs_err == 0, "R5 select level errors", cs_err, 0);
    chk(rs_err == 0, "R2 register select errors", rs_err, 0);
    if (!par) begin
      chk(nlead == 8, "R3 leading edge count", nlead, 8);
      chk(cap == b, "R3 byte MSB first", cap, b);
      chk(first_lead == 3*H + 1, "R4 first leading edge", first_lead, 3*H + 1);
      chk(first_lead - 1 >= 2*H, "R6 select setup", first_lead - 1, 2*H);
      chk(last_trail == T + 1 - 2*H, "R6 select hold", last_trail, T + 1 - 2*H);
      chk(nwr == 0, "R7 no strobe in serial", nwr, 0);
    end else begin
      chk(nwr == 1, "R7 strobe count", nwr, 1);
      chk(pcap == b, "R7 parallel byte", pcap, b);
      chk(wr_hi == H, "R7 strobe width", wr_hi, H);
      chk(nlead == 0, "R7 clock quiet", nlead, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h5A; pats[2] = 8'h01; pats[3] = 8'hFE;
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 1'b0, "R10 busy in reset", busy, 0);
    chk(lcd_cs == 1'b1, "R10 select inactive", lcd_cs, 1);
    chk(lcd_sclk == 1'b0, "R10 clock idle", lcd_sclk, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
    chk(busy == 1'b0, "R10 idle after reset", busy, 0);
    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 2; d++)
        for (int p = 0; p < 4; p++)
          xfer(pats[p], d[0], m[2], m[1], m[0]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule